// File: doc/BRIEF.md
# Serial-In Latched-Output Shift Register

The block is a serial-to-parallel converter with two independently clocked stages. A bit arrives on `ser_in` and moves one position along a chain of `W` flops on each rising edge of `shift_clk`. A rising edge of `store_clk` copies the whole chain into a holding latch. The holding latch drives `par_q` while `oe_n` is low. Because the two stages have separate clocks, a new word can be shifted in while the previous word stays on the outputs. The new word then appears on all outputs at once, on the next storage edge.

The last chain stage is brought out on `ser_out`. Several copies can share `shift_clk`, `store_clk` and `clr_n`, with each `ser_out` feeding the next copy's `ser_in`, to form a wider register. `clr_n` empties the chain without waiting for a clock and leaves the holding latch as it is. When `oe_n` is high, every parallel output is released to high impedance.

Top module: `sipo_latch_reg`

## Requirements
- R1: On each rising edge of `shift_clk` with `clr_n` high, chain stage 0 takes `ser_in` and stage i takes the previous value of stage i-1. `par_q[i]` shows stage i, so after W shifts followed by a storage edge, `par_q[W-1]` holds the first bit shifted.
- R2: On a rising edge of `store_clk`, all W chain stages are copied into the holding latch. While `oe_n` is low, `par_q` equals the holding latch.
- R3: While `oe_n` is high, every bit of `par_q` is high impedance. The holding latch is not changed, and it reappears on `par_q` when `oe_n` returns low.
- R4: While `clr_n` is low, every chain stage is 0 and `ser_out` is 0, with no clock edge needed.
- R5: `ser_out` equals the last chain stage. It changes only on a shift edge or a clear, and is unaffected by `store_clk` and `oe_n`.
- R6: `clr_n` does not change the holding latch. `par_q` keeps its value through a clear until the next storage edge.
- R7: Shift edges without a storage edge leave `par_q` unchanged.
- R8: When two copies are chained through `ser_out`, after 2W shifts and one storage edge, the far copy shows the first W bits shifted and the near copy shows the last W bits.
- R9: When `store_clk` and `shift_clk` rise together, the holding latch takes the chain contents from before that shift.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clr_n | input | 1 | Active-low asynchronous clear of the shift chain |
| shift_clk | input | 1 | Shift clock, rising-edge active |
| store_clk | input | 1 | Storage clock, rising-edge active |
| ser_in | input | 1 | Serial data into chain stage 0 |
| oe_n | input | 1 | Active-low output enable for `par_q` |
| par_q | output | W | Parallel outputs from the holding latch; high impedance when disabled |
| ser_out | output | 1 | Cascade output, equal to the last chain stage |

## Verification
A wrong chain stage shows at the ports in one of two ways. It reaches `ser_out` after at most W-1 further shift edges, or it appears on `par_q` at the next storage edge. The bench therefore compares both against a queue model after every clock. A holding-latch fault shows on `par_q` straight away while the outputs are enabled. That includes a latch that was wrongly cleared, or one that moves without a storage edge. An output-enable fault shows as a pulled level in place of the driven word, or as a driven word in place of the pulled level.

// File: rtl/ssr_pkg.sv
package ssr_pkg;
   typedef enum logic {
      OUT_DRIVEN = 1'b0,
      OUT_FLOAT  = 1'b1
   } out_state_e;
endpackage

// File: rtl/ssr_shift_chain.sv
module ssr_shift_chain #(
   parameter int W = 8
) (
   input  logic         shift_clk,
   input  logic         clr_n,
   input  logic         din,
   output logic [W-1:0] stages
);
   generate
      for (genvar i = 0; i < W; i++) begin : g_stage
         logic bit_q;
         logic bit_d;
         if (i == 0) begin : g_head
            assign bit_d = din;
         end else begin : g_body
            assign bit_d = stages[i-1];
         end
         always_ff @(posedge shift_clk or negedge clr_n) begin
            if (!clr_n) bit_q <= 1'b0;
            else        bit_q <= bit_d;
         end
         assign stages[i] = bit_q;
      end
   endgenerate
endmodule

// File: rtl/ssr_hold_latch.sv
module ssr_hold_latch #(
   parameter int W = 8
) (
   input  logic         store_clk,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   always_ff @(posedge store_clk) begin
      q <= d;
   end
endmodule

// File: rtl/ssr_pad_drv.sv
module ssr_pad_drv #(
   parameter int W = 8
) (
   input  logic         oe_n,
   input  logic [W-1:0] d,
   output wire  [W-1:0] pad
);
   import ssr_pkg::*;
   out_state_e mode;
   assign mode = oe_n ? OUT_FLOAT : OUT_DRIVEN;
   assign pad  = (mode == OUT_DRIVEN) ? d : {W{1'bz}};
endmodule

// File: rtl/sipo_latch_reg.sv
module sipo_latch_reg #(
   parameter int W = 8
) (
   input  logic         clr_n,
   input  logic         shift_clk,
   input  logic         store_clk,
   input  logic         ser_in,
   input  logic         oe_n,
   output wire  [W-1:0] par_q,
   output logic         ser_out
);
   localparam int LAST = W - 1;

   if (W < 2) begin : g_bad_width
      $error("sipo_latch_reg: W must be at least 2");
   end

   logic [W-1:0] sr_q;
   logic [W-1:0] latch_q;

   ssr_shift_chain #(.W(W)) i_chain (
      .shift_clk (shift_clk),
      .clr_n     (clr_n),
      .din       (ser_in),
      .stages    (sr_q)
   );

   ssr_hold_latch #(.W(W)) i_hold (
      .store_clk (store_clk),
      .d         (sr_q),
      .q         (latch_q)
   );

   ssr_pad_drv #(.W(W)) i_pad (
      .oe_n (oe_n),
      .d    (latch_q),
      .pad  (par_q)
   );

   assign ser_out = sr_q[LAST];
endmodule

// File: rtl/ssr_chk.sv
module ssr_chk #(
   parameter int W = 8
) (
   input logic         clr_n,
   input logic         shift_clk,
   input logic         store_clk,
   input logic         ser_in,
   input logic         oe_n,
   input logic [W-1:0] sr_q,
   input logic [W-1:0] latch_q,
   input logic [W-1:0] par_q,
   input logic         ser_out
);
   logic         armed;
   logic         cleared;
   logic         seen_st;
   logic         st_tog;
   logic [W-1:0] snap;

   always_ff @(posedge shift_clk or negedge clr_n) begin
      if (!clr_n) begin
         armed   <= 1'b0;
         cleared <= 1'b1;
      end else begin
         armed   <= 1'b1;
         cleared <= 1'b0;
      end
   end

   always_ff @(posedge store_clk or negedge clr_n) begin
      if (!clr_n) begin
         seen_st <= 1'b0;
         st_tog  <= 1'b0;
      end else begin
         seen_st <= 1'b1;
         st_tog  <= ~st_tog;
      end
   end

   always_ff @(posedge store_clk) begin
      snap <= sr_q;
   end

   AST_SHIFT_ADVANCE: assert property (@(posedge shift_clk) disable iff (!clr_n)
      armed |-> sr_q == {$past(sr_q[W-2:0]), $past(ser_in)}); // R1

   AST_STORE_COPY: assert property (@(posedge store_clk) disable iff (!clr_n)
      seen_st |-> latch_q == snap); // R2

   AST_PAD_FOLLOWS_LATCH: assert property (@(posedge store_clk) disable iff (!clr_n)
      (seen_st && !oe_n) |-> par_q == latch_q); // R2

   AST_CLEAR_EMPTY: assert property (@(posedge shift_clk) disable iff (!clr_n)
      cleared |-> (sr_q == '0 && ser_out == 1'b0)); // R4

   AST_CASCADE_TAIL: assert property (@(posedge shift_clk) disable iff (!clr_n)
      armed |-> ser_out == $past(sr_q[W-2])); // R5

   AST_LATCH_HOLD: assert property (@(posedge shift_clk) disable iff (!clr_n)
      (armed && seen_st && $past(seen_st) && $stable(st_tog)) |-> $stable(latch_q)); // R7
endmodule

bind sipo_latch_reg ssr_chk #(.W(W)) i_chk (
   .clr_n     (clr_n),
   .shift_clk (shift_clk),
   .store_clk (store_clk),
   .ser_in    (ser_in),
   .oe_n      (oe_n),
   .sr_q      (sr_q),
   .latch_q   (latch_q),
   .par_q     (par_q),
   .ser_out   (ser_out)
);

// File: tb/test_sipo_latch_reg.sv
`timescale 1ns/1ps
module test_sipo_latch_reg;
   localparam int W = 8;

   logic clk = 1'b0;
   logic clr_n = 1'b0;
   logic shift_clk = 1'b0;
   logic store_clk = 1'b0;
   logic ser_in = 1'b0;
   logic oe_n = 1'b1;

   tri1 [W-1:0] near_par;
   tri0 [W-1:0] far_par;
   logic link;
   logic far_out;

   int checks = 0;
   int fails = 0;
   bit running = 1'b0;

   bit q[$];
   logic [W-1:0] lat_n, lat_f;
   bit lat_known = 1'b0;

   always #2.5 clk = ~clk;

   sipo_latch_reg #(.W(W)) i_sipo_latch_reg (
      .clr_n(clr_n), .shift_clk(shift_clk), .store_clk(store_clk),
      .ser_in(ser_in), .oe_n(oe_n), .par_q(near_par), .ser_out(link));

   sipo_latch_reg #(.W(W)) i_far (
      .clr_n(clr_n), .shift_clk(shift_clk), .store_clk(store_clk),
      .ser_in(link), .oe_n(oe_n), .par_q(far_par), .ser_out(far_out));

   task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
      end
   endtask

   function automatic logic [W-1:0] model_word(input int base);
      logic [W-1:0] v;
      for (int i = 0; i < W; i++) v[i] = q[base + i];
      return v;
   endfunction

   always @(posedge clk) begin
      if (running) begin
         chk("R5 near cascade", {15'd0, link}, {15'd0, q[W-1]});
         chk("R5 far cascade", {15'd0, far_out}, {15'd0, q[2*W-1]});
         if (oe_n) begin
            chk("R3 near hi-z", {8'd0, near_par}, {8'd0, {W{1'b1}}});
            chk("R3 far hi-z", {8'd0, far_par}, 16'd0);
         end else if (lat_known) begin
            chk("R2 near outputs", {8'd0, near_par}, {8'd0, lat_n});
            chk("R2 far outputs", {8'd0, far_par}, {8'd0, lat_f});
         end
      end
   end

   task automatic step(input bit do_shift, input bit do_store, input bit b);
      @(negedge clk);
      ser_in = b;
      @(negedge clk);
      if (do_store) begin
         lat_n = model_word(0);
         lat_f = model_word(W);
         lat_known = 1'b1;
      end
      if (do_shift) begin
         q.push_front(b);
         void'(q.pop_back());
      end
      shift_clk = do_shift;
      store_clk = do_store;
      @(negedge clk);
      shift_clk = 1'b0;
      store_clk = 1'b0;
   endtask

   task automatic shift_byte(input logic [W-1:0] v);
      for (int i = W - 1; i >= 0; i--) step(1'b1, 1'b0, v[i]);
   endtask

   task automatic do_clear();
      @(negedge clk);
      clr_n = 1'b0;
      for (int i = 0; i < 2 * W; i++) q[i] = 1'b0;
      @(posedge clk);
      #1;
      chk("R4 async clear near", {15'd0, link}, 16'd0);
      chk("R4 async clear far", {15'd0, far_out}, 16'd0);
      @(negedge clk);
      clr_n = 1'b1;
   endtask

   initial begin
      #(200000 * 5);
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      for (int i = 0; i < 2 * W; i++) q.push_back(1'b0);
      repeat (3) @(negedge clk);
      do_clear();
      running = 1'b1;
      chk("R4 reset cascade", {15'd0, far_out}, 16'd0);
      chk("R3 reset outputs hi-z", {8'd0, near_par}, 16'h00ff);

      // R1 / R2: one word into the near device, then store
      shift_byte(8'hA5);
      step(1'b0, 1'b1, 1'b0);
      @(negedge clk); oe_n = 1'b0;
      @(posedge clk); #1;
      chk("R1 word order near", {8'd0, near_par}, 16'h00A5);
      chk("R8 far holds leftover", {8'd0, far_par}, 16'h0000);

      // R7: shifting alone leaves outputs
      shift_byte(8'h3C);
      @(posedge clk); #1;
      chk("R7 no store no change", {8'd0, near_par}, 16'h00A5);

      // R8: chain two words
      shift_byte(8'h5E);
      step(1'b0, 1'b1, 1'b0);
      @(posedge clk); #1;
      chk("R8 far gets first word", {8'd0, far_par}, 16'h003C);
      chk("R8 near gets last word", {8'd0, near_par}, 16'h005E);

      // R6: clear keeps latched outputs
      do_clear();
      @(posedge clk); #1;
      chk("R6 near latch kept", {8'd0, near_par}, 16'h005E);
      chk("R6 far latch kept", {8'd0, far_par}, 16'h003C);

      // R3: disable and re-enable
      @(negedge clk); oe_n = 1'b1;
      @(posedge clk); #1;
      chk("R3 near floats", {8'd0, near_par}, 16'h00ff);
      chk("R3 far floats", {8'd0, far_par}, 16'h0000);
      chk("R5 cascade ignores oe", {15'd0, far_out}, 16'd0);
      @(negedge clk); oe_n = 1'b0;
      @(posedge clk); #1;
      chk("R3 near restored", {8'd0, near_par}, 16'h005E);

      // R9: store and shift on the same edge
      shift_byte(8'hC3);
      step(1'b1, 1'b1, 1'b1);
      @(posedge clk); #1;
      chk("R9 pre-shift word near", {8'd0, near_par}, 16'h00C3);
      chk("R5 cascade after store", {15'd0, link}, 16'd1);
      step(1'b0, 1'b1, 1'b0);
      @(posedge clk); #1;
      chk("R9 post-shift word near", {8'd0, near_par}, 16'h0087);

      running = 1'b0;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule